// File: doc/BRIEF.md
# Channel-Major Sample Word Packer

The packer sits between a multi-channel sampler and a word-oriented transport. Every sample strobe delivers one parallel sample in which bit `c` is the current level of channel `c`. The block transposes these samples. It gathers a group of consecutive samples and then emits, for each enabled channel, one output word that holds that channel's samples for the whole group. With the default sizes there are 16 channels and 64 samples per group, so each output word is 64 bits wide.

The output is a valid/ready stream. Each beat carries the channel index, and a marker flags the final word of a group. The block keeps two copies of the per-channel storage. While one group is being sent downstream, the next group is collected in the other copy. If a group completes while words of the previous group are still waiting, the new group is discarded and a sticky overflow flag is raised. A flush input closes a partly filled group. The missing sample positions are filled with zeros and the group is emitted.

Top module: `chan_word_packer`

## Requirements
- R1: In every output word, bit n equals the level of the word's channel in the n-th sample of its group, with n counted from 0 at the oldest sample.
- R2: The words of one group leave in strictly ascending channel index order, and `out_chan` gives the channel number. `out_last` is 1 only on the word with the highest enabled index. After a non-last word is accepted, the next word is valid in the following cycle.
- R3: A channel whose mask bit is 0 produces no word. A group completed with an all-zero mask produces no output at all.
- R4: Each complete group yields exactly as many words as there are set bits in the mask, so the output length is 8 bytes times the enabled channel count per group.
- R5: Groups arriving back to back, with a strobe every cycle and `out_ready` held at 1 (or toggling with all 16 channels enabled), are all emitted without loss and `overflow` stays 0.
- R6: If a group completes while words of the previous group are still waiting to be sent, that new group is dropped whole and `overflow` becomes 1. The flag stays 1 until reset, and the earlier group is still delivered intact.
- R7: Asserting `flush` while a group holds at least one sample (a strobe in the same cycle counts as part of the group) emits the group, with zeros in the positions that were never filled. A flush with an empty group emits nothing.
- R8: While `rst` is high and in the cycle after it, `out_valid` and `overflow` are 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_chan` and `out_last` hold their values.
- R10: The channel mask is sampled in the cycle of the strobe (or flush) that completes a group. Changes to the mask at any other time do not affect that group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe: `smp_data` is taken this cycle |
| smp_data | input | NUM_CH (16) | One parallel sample, bit c = channel c |
| ch_mask | input | NUM_CH (16) | Channel enable mask, bit c enables channel c |
| flush | input | 1 | Close the current partial group and emit it zero-padded |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | Output word is valid |
| out_data | output | GRP_LEN (64) | Samples of one channel for one group |
| out_chan | output | IDX_W (4) | Channel index of `out_data` |
| out_last | output | 1 | Last word of the group |
| overflow | output | 1 | Sticky flag: a group was dropped |

## Verification
The transposition is tried with several kinds of mask: all 16 channels, each end channel alone, sparse alternating masks, the two end channels together, and an empty mask. Each sample value is derived from a seed and its position, so a swapped bit, a swapped channel or a wrongly ordered word shows up as a data mismatch. These patterns are run with `out_ready` held high, with `out_ready` toggling, and with gaps between strobes. Together they separate correct channel ordering and last-word marking from a design that emits disabled channels or mixes up positions. Directed cases cover the following: a mask change on exactly the completing strobe; flushes after ten samples, on a strobe, and with nothing pending; and a stalled downstream that forces a dropped group while the held word must stay still.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int unsigned DEF_NUM_CH  = 16;
  localparam int unsigned DEF_GRP_LEN = 64;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int unsigned low_index(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/cwp_collect.sv
module cwp_collect
  import cwp_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned GRP_LEN = DEF_GRP_LEN
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              stb,
  input  logic [NUM_CH-1:0]                 data,
  input  logic                              flush,
  output logic                              done,
  output logic [NUM_CH-1:0][GRP_LEN-1:0]    words
);
  localparam int unsigned CNT_W = (GRP_LEN > 1) ? $clog2(GRP_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GRP_LEN - 1);

  logic [CNT_W-1:0]                 pos;
  logic [NUM_CH-1:0][GRP_LEN-1:0]   acc;
  logic                             full_grp;
  logic                             part_grp;

  // Current group with this cycle's sample merged at its position.
  always_comb begin
    words = acc;
    if (stb) begin
      for (int c = 0; c < NUM_CH; c++) begin
        words[c][pos] = data[c];
      end
    end
  end

  assign full_grp = stb && (pos == LAST_POS);
  assign part_grp = flush && (stb || (pos != '0));
  assign done     = full_grp || part_grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      acc <= '0;
    end else if (done) begin
      pos <= '0;
      acc <= '0;
    end else if (stb) begin
      acc <= words;
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/cwp_bank.sv
module cwp_bank
  import cwp_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned GRP_LEN = DEF_GRP_LEN,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                              clk,
  input  logic                              load,
  input  logic [NUM_CH-1:0][GRP_LEN-1:0]    wr_words,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [GRP_LEN-1:0]                rd_word
);
  logic [GRP_LEN-1:0] mem [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) mem[g] <= wr_words[g];
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/cwp_seq.sv
module cwp_seq
  import cwp_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned GRP_LEN = DEF_GRP_LEN,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 grp_done,
  input  logic [NUM_CH-1:0]    grp_mask,
  input  logic [GRP_LEN-1:0]   rd_word,
  input  logic                 out_ready,
  output logic                 load,
  output logic [IDX_W-1:0]     rd_idx,
  output logic                 out_valid,
  output logic [GRP_LEN-1:0]   out_data,
  output logic [IDX_W-1:0]     out_chan,
  output logic                 out_last,
  output logic                 overflow
);
  logic [NUM_CH-1:0] rem;
  logic [NUM_CH-1:0] rem_after;
  logic [NUM_CH-1:0] pick;
  logic              pop;
  logic              mask_any;

  always_comb begin
    rd_idx    = IDX_W'(low_index(32'(rem)));
    pop       = (rem != '0) && (!out_valid || out_ready);
    pick      = '0;
    pick[rd_idx] = 1'b1;
    rem_after = pop ? (rem & ~pick) : rem;
    mask_any  = (grp_mask != '0);
    load      = grp_done && mask_any && (rem_after == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
      out_last  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      rem <= load ? grp_mask : rem_after;
      if (grp_done && mask_any && (rem_after != '0)) overflow <= 1'b1;
      if (pop) begin
        out_valid <= 1'b1;
        out_data  <= rd_word;
        out_chan  <= rd_idx;
        out_last  <= (rem_after == '0);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chan_word_packer.sv
module chan_word_packer
  import cwp_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned GRP_LEN = DEF_GRP_LEN,
  localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic [NUM_CH-1:0]    smp_data,
  input  logic [NUM_CH-1:0]    ch_mask,
  input  logic                 flush,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [GRP_LEN-1:0]   out_data,
  output logic [IDX_W-1:0]     out_chan,
  output logic                 out_last,
  output logic                 overflow
);
  logic                             grp_done;
  logic [NUM_CH-1:0][GRP_LEN-1:0]   grp_words;
  logic                             bank_load;
  logic [IDX_W-1:0]                 rd_idx;
  logic [GRP_LEN-1:0]               rd_word;

  cwp_collect #(.NUM_CH(NUM_CH), .GRP_LEN(GRP_LEN)) u_collect (
    .clk   (clk),
    .rst   (rst),
    .stb   (smp_stb),
    .data  (smp_data),
    .flush (flush),
    .done  (grp_done),
    .words (grp_words)
  );

  cwp_bank #(.NUM_CH(NUM_CH), .GRP_LEN(GRP_LEN), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .load     (bank_load),
    .wr_words (grp_words),
    .rd_idx   (rd_idx),
    .rd_word  (rd_word)
  );

  cwp_seq #(.NUM_CH(NUM_CH), .GRP_LEN(GRP_LEN), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .grp_done  (grp_done),
    .grp_mask  (ch_mask),
    .rd_word   (rd_word),
    .out_ready (out_ready),
    .load      (bank_load),
    .rd_idx    (rd_idx),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .out_last  (out_last),
    .overflow  (overflow)
  );
endmodule

// File: rtl/chan_word_packer_chk.sv
module chan_word_packer_chk #(
  parameter int unsigned GRP_LEN = 64,
  parameter int unsigned IDX_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               out_ready,
  input logic               out_valid,
  input logic [GRP_LEN-1:0] out_data,
  input logic [IDX_W-1:0]   out_chan,
  input logic               out_last,
  input logic               overflow
);
  logic             mid_grp;
  logic [IDX_W-1:0] prev_chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_grp   <= 1'b0;
      prev_chan <= '0;
    end else if (out_valid && out_ready) begin
      mid_grp   <= !out_last;
      prev_chan <= out_chan;
    end
  end

  // R8: reset leaves the stream idle and the flag clear
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && !overflow));

  // R9: a stalled word does not change
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_last)));

  // R6: overflow is sticky
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R2: channels rise within a group
  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mid_grp) |-> (out_chan > prev_chan));

  // R2: no bubble inside a group
  a_r2_no_gap: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> out_valid);
endmodule

bind chan_word_packer chan_word_packer_chk #(.GRP_LEN(GRP_LEN), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_chan  (out_chan),
  .out_last  (out_last),
  .overflow  (overflow)
);

// File: tb/sim_chan_word_packer.sv
module sim_chan_word_packer;
  localparam int NCH = 16;
  localparam int GL  = 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           smp_stb = 1'b0;
  logic [15:0]    smp_data = '0;
  logic [15:0]    ch_mask = '0;
  logic           flush = 1'b0;
  logic           out_ready = 1'b1;
  logic           out_valid;
  logic [63:0]    out_data;
  logic [3:0]     out_chan;
  logic           out_last;
  logic           overflow;

  chan_word_packer #(.NUM_CH(NCH), .GRP_LEN(GL)) u0 (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data),
    .ch_mask(ch_mask), .flush(flush), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
    .out_last(out_last), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  int ready_mode = 0;   // 0 high, 1 toggle, 2 low
  int gcnt = 0;
  logic [15:0] grp [GL];
  logic [68:0] exp_q [$];
  logic [68:0] e;

  // {mask, seed, groups, toggle ready, strobe gaps}
  localparam logic [41:0] VEC [8] = '{
    {16'hFFFF, 16'h1234, 8'd1, 1'b0, 1'b0},
    {16'h0001, 16'hBEEF, 8'd1, 1'b0, 1'b0},
    {16'h8000, 16'h4C1D, 8'd1, 1'b1, 1'b0},
    {16'hA5A5, 16'h0F0F, 8'd2, 1'b1, 1'b0},
    {16'h0000, 16'h5555, 8'd1, 1'b0, 1'b0},
    {16'h8001, 16'h7E81, 8'd3, 1'b1, 1'b1},
    {16'h00F0, 16'hC3C3, 8'd1, 1'b0, 1'b1},
    {16'hFFFF, 16'h9A6B, 8'd4, 1'b0, 1'b0}
  };

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] samp(input logic [15:0] seed, input int k);
    return 16'(seed * (k + 3)) ^ 16'(k << 7) ^ {seed[7:0], seed[15:8]};
  endfunction

  // Output monitor: compares accepted words with the model queue (R1, R2, R3)
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      rx_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected word", out_data, 64'd0);
      end else begin
        e = exp_q.pop_front();
        chk(out_data == e[63:0], "R1", "word data", out_data, e[63:0]);
        chk({out_last, out_chan} == e[68:64], "R2", "last/channel",
            64'({out_last, out_chan}), 64'(e[68:64]));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        default: out_ready = 1'b0;
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push_group(input logic [15:0] msk, input int n);
    logic [63:0] w;
    for (int c = 0; c < NCH; c++) begin
      if (msk[c]) begin
        w = '0;
        for (int b = 0; b < n; b++) w[b] = grp[b][c];
        exp_q.push_back({((msk >> (c + 1)) == 16'd0), 4'(c), w});
      end
    end
  endtask

  task automatic put_sample(input logic [15:0] d, input bit fl);
    smp_stb = 1'b1; smp_data = d; flush = fl;
    grp[gcnt] = d;
    gcnt++;
    if (gcnt == GL || fl) begin
      push_group(ch_mask, gcnt);
      gcnt = 0;
    end
    tick();
    smp_stb = 1'b0; flush = 1'b0;
  endtask

  task automatic raw_sample(input logic [15:0] d);
    smp_stb = 1'b1; smp_data = d;
    tick();
    smp_stb = 1'b0;
  endtask

  task automatic flush_only();
    flush = 1'b1;
    if (gcnt > 0) begin
      push_group(ch_mask, gcnt);
      gcnt = 0;
    end
    tick();
    flush = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || out_valid) && guard < 3000) begin
      tick();
      guard++;
    end
    repeat (3) tick();
  endtask

  initial begin
    logic [15:0] m, s;
    logic [7:0]  ng;
    logic        rd, gp;
    logic [63:0] held;
    int base;

    // R8: reset state
    rst = 1'b1;
    repeat (4) tick();
    chk(out_valid == 1'b0, "R8", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(overflow == 1'b0, "R8", "overflow in reset", 64'(overflow), 64'd0);
    rst = 1'b0;
    tick();
    chk(out_valid == 1'b0, "R8", "out_valid after reset", 64'(out_valid), 64'd0);

    // Table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      {m, s, ng, rd, gp} = VEC[v];
      ch_mask = m;
      ready_mode = int'(rd);
      base = rx_cnt;
      for (int g = 0; g < int'(ng); g++) begin
        for (int k = 0; k < GL; k++) begin
          put_sample(samp(s, g * GL + k), 1'b0);
          if (gp) repeat (2) tick();
        end
      end
      drain();
      chk(rx_cnt - base == $countones(m) * int'(ng), (m == 16'd0) ? "R3" : "R4",
          "word count", 64'(rx_cnt - base), 64'($countones(m) * int'(ng)));
      chk(overflow == 1'b0, "R5", "overflow at full rate", 64'(overflow), 64'd0);
    end
    ready_mode = 0;

    // R10: mask taken on the completing strobe
    ch_mask = 16'h0003;
    base = rx_cnt;
    for (int k = 0; k < GL - 1; k++) put_sample(samp(16'h2468, k), 1'b0);
    ch_mask = 16'h0C00;
    put_sample(samp(16'h2468, GL - 1), 1'b0);
    ch_mask = 16'h0003;
    drain();
    chk(rx_cnt - base == 2, "R10", "words for late mask", 64'(rx_cnt - base), 64'd2);

    // R7: flush after ten samples, zero padding
    ch_mask = 16'h0005;
    base = rx_cnt;
    for (int k = 0; k < 10; k++) put_sample(samp(16'h1357, k), 1'b0);
    flush_only();
    drain();
    chk(rx_cnt - base == 2, "R7", "words after flush", 64'(rx_cnt - base), 64'd2);

    // R7: flush together with a strobe
    base = rx_cnt;
    for (int k = 0; k < 5; k++) put_sample(samp(16'hFACE, k), 1'b0);
    put_sample(samp(16'hFACE, 5), 1'b1);
    drain();
    chk(rx_cnt - base == 2, "R7", "words for flush with strobe", 64'(rx_cnt - base), 64'd2);

    // R7: flush of an empty group
    base = rx_cnt;
    flush_only();
    drain();
    chk(rx_cnt - base == 0, "R7", "words for empty flush", 64'(rx_cnt - base), 64'd0);

    // R6 / R9: stalled downstream, second group dropped
    ready_mode = 2;
    repeat (2) tick();
    ch_mask = 16'h0003;
    base = rx_cnt;
    for (int k = 0; k < GL; k++) put_sample(samp(16'h0BAD, k), 1'b0);
    repeat (3) tick();
    chk(out_valid == 1'b1, "R9", "valid while stalled", 64'(out_valid), 64'd1);
    held = out_data;
    for (int k = 0; k < GL; k++) raw_sample(samp(16'h7777, k));
    repeat (3) tick();
    chk(out_valid == 1'b1 && out_data == held, "R9", "held word", out_data, held);
    chk(overflow == 1'b1, "R6", "overflow raised", 64'(overflow), 64'd1);
    ready_mode = 0;
    drain();
    chk(rx_cnt - base == 2, "R6", "only first group delivered", 64'(rx_cnt - base), 64'd2);
    chk(overflow == 1'b1, "R6", "overflow sticky", 64'(overflow), 64'd1);

    // R8: reset clears the flag
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    tick();
    chk(overflow == 1'b0, "R8", "overflow after reset", 64'(overflow), 64'd0);
    chk(out_valid == 1'b0, "R8", "valid after reset", 64'(out_valid), 64'd0);

    finish_up();
  end
endmodule